// File: doc/BRIEF.md
# QSPI FIFO Data Port

This block is the host-facing data path of a quad-SPI engine. A processor moves payload bytes into a transmit FIFO and collects received bytes from a receive FIFO through a simple register bus. The serial engine behind it consumes and produces one byte at a time over a valid/take handshake. Each FIFO has two windows. A byte window moves one byte per access. A word window moves four bytes per 32-bit access and only works while the wide-access flag in the control register is set.

A status register reports FIFO levels, sticky completion events from the sequencer and the sequencer's idle state. The empty and full indications follow the access width in force, so software polling a flag always knows whether one more access of the current width can succeed. An enable mask gates the low status bits onto a single interrupt line.

Top module: `qspi_fifo_port`

## Requirements
- R1: After reset, both FIFOs are empty, the wide flag and the interrupt enables are zero, status reads 0x18 (transmit space and receive empty set) while the sequencer is busy, and the interrupt line is low.
- R2: A write to the transmit byte window (0x44) queues bits 7:0 and ignores the upper bits. Queued bytes leave on the sequencer side in write order.
- R3: A read of the receive byte window (0x40) removes the oldest byte and returns it in bits 7:0, with bits 31:8 zero.
- R4: Control register (0x00) bit 16 is the wide flag. It reads back and is mirrored in status bit 8. While it is clear, writes to the word windows queue nothing, and reads of the word windows return zero and remove nothing.
- R5: With the wide flag set, a write to the transmit word window (0x4C) queues four bytes: bits 7:0 first and bits 31:24 last.
- R6: With the wide flag set, a read of the receive word window (0x48) removes four bytes and returns the oldest in bits 7:0 and the fourth in bits 31:24.
- R7: Each FIFO holds 16 bytes. A transmit write that does not fit completely (one byte into 16 used entries, or four bytes into fewer than four free entries) is dropped whole.
- R8: A receive read that finds fewer bytes than its width returns zero and leaves the FIFO contents unchanged.
- R9: Status bit 4 (receive empty) is set while fewer than N bytes are buffered, and status bit 5 (transmit full) is set while fewer than N entries are free, where N is 4 with the wide flag set and 1 otherwise. Bits 2 and 3 are the complements of bits 4 and 5.
- R10: Status bits 0 and 1 latch transmit-done and receive-done pulses from the sequencer and hold until a status write with a 1 in that bit; a pulse in the same cycle wins. Status bit 7 follows the sequencer idle input.
- R11: The interrupt enable register (0x0C, bits 5:0) reads back, and the interrupt line is the OR of status bits 5:0 each ANDed with its enable.
- R12: The sequencer side offers a transmit byte while any is queued and takes it on a cycle with valid and take both high. It accepts a receive byte on a cycle with valid and room both high, and room is high while the receive FIFO holds fewer than 16 bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after the read strobe |
| tx_byte | output | 8 | Oldest queued transmit byte |
| tx_valid | output | 1 | Transmit FIFO not empty |
| tx_take | input | 1 | Sequencer consumes tx_byte |
| rx_byte | input | 8 | Received byte from the sequencer |
| rx_valid | input | 1 | rx_byte is present |
| rx_room | output | 1 | Receive FIFO can accept a byte |
| seq_tx_done | input | 1 | Pulse: transmit phase finished |
| seq_rx_done | input | 1 | Pulse: receive phase finished |
| seq_idle | input | 1 | Sequencer ready for a new frame |
| irq | output | 1 | Masked OR of status events |

## Verification
The assertions assume that the bus raises at most one of read and write in a cycle, and that the sequencer raises take only while a byte is offered and valid only while room is shown. The stimulus keeps to this: every bus access is a single one-cycle strobe with an idle cycle after it. Transmit draining is bounded by the bench's own count of queued bytes. Receive bytes are fed only while the bench's model shows room, except in one deliberate overfill. That overfill drives valid with room low, and the check is that nothing extra arrives.

// File: rtl/qfp_pkg.sv
`timescale 1ns/1ps
// Package: shared register offsets, status bit positions and the access
// decode type for the QSPI FIFO data port. Offsets are byte addresses that
// software decodes, so they are fixed here.
package qfp_pkg;
    localparam int OFS_CTRL = 'h00;
    localparam int OFS_IEN  = 'h0C;
    localparam int OFS_STAT = 'h10;
    localparam int OFS_RXB  = 'h40;
    localparam int OFS_TXB  = 'h44;
    localparam int OFS_RXW  = 'h48;
    localparam int OFS_TXW  = 'h4C;

    localparam int CTRL_WIDE_BIT = 16;
    localparam int IEN_W         = 6;

    localparam int ST_TXDONE = 0;
    localparam int ST_RXDONE = 1;
    localparam int ST_RXAVL  = 2;
    localparam int ST_TXAVL  = 3;
    localparam int ST_RXEMP  = 4;
    localparam int ST_TXFUL  = 5;
    localparam int ST_READY  = 7;
    localparam int ST_WIDE   = 8;

    typedef enum logic [2:0] {
        ACC_NONE, ACC_CTRL, ACC_IEN, ACC_STAT,
        ACC_RXB, ACC_TXB, ACC_RXW, ACC_TXW
    } acc_e;
endpackage

// File: rtl/qfp_fifo.sv
`timescale 1ns/1ps
// Byte FIFO with multi-lane push and pop. Up to LANES bytes enter or leave
// per cycle, and lane 0 is always the oldest byte.
// Assumes: DEPTH is a power of two, the caller never pushes more than the
// free space and never pops more than the fill count (both judged on the
// count before this cycle).
module qfp_fifo #(
    parameter int DEPTH = 16,
    parameter int LANES = 4,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int LN_W  = $clog2(LANES + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [LN_W-1:0]    push_n,
    input  logic [LANES*8-1:0] push_data,
    input  logic [LN_W-1:0]    pop_n,
    output logic [LANES*8-1:0] head,
    output logic [CNT_W-1:0]   count
);
    logic [7:0]       mem [DEPTH];
    logic [PTR_W-1:0] wptr, rptr;

    // Storage write: lane i lands i slots past the write pointer.
    always_ff @(posedge clk) begin
        for (int i = 0; i < LANES; i++) begin
            if (LN_W'(i) < push_n)
                mem[wptr + PTR_W'(i)] <= push_data[8*i +: 8];
        end
    end

    // Pointer and fill-count update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            wptr  <= wptr + PTR_W'(push_n);
            rptr  <= rptr + PTR_W'(pop_n);
            count <= count + CNT_W'(push_n) - CNT_W'(pop_n);
        end
    end

    // Head window: the LANES oldest entries, oldest in lane 0.
    for (genvar g = 0; g < LANES; g++) begin : g_head
        assign head[8*g +: 8] = mem[rptr + PTR_W'(g)];
    end

    a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));
    a_r7_push_fits: assert property (@(posedge clk) disable iff (!rst_n)
        (push_n != '0) |-> (CNT_W'(push_n) <= CNT_W'(DEPTH) - count));
    a_r8_pop_covered: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_n != '0) |-> (CNT_W'(pop_n) <= count));
endmodule

// File: rtl/qfp_status.sv
`timescale 1ns/1ps
// Status word and interrupt. Level flags come from the FIFO fill counts,
// with thresholds set by the wide-access flag. The two done flags are
// sticky and cleared by write-one. The interrupt is the masked OR of the
// low status bits.
// Assumes: the done inputs are single-cycle pulses, and clr is a write
// strobe already qualified by the status address.
module qfp_status
    import qfp_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int LANES  = 4,
    parameter int DATA_W = 32,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  tx_cnt,
    input  logic [CNT_W-1:0]  rx_cnt,
    input  logic              wide,
    input  logic              seq_tx_done,
    input  logic              seq_rx_done,
    input  logic              seq_idle,
    input  logic [1:0]        clr,
    input  logic [IEN_W-1:0]  ien,
    output logic [DATA_W-1:0] status,
    output logic              irq
);
    logic [1:0]       done_q;
    logic [CNT_W-1:0] need, tx_free;
    logic             rx_short, tx_tight;

    // Sticky done flags: a new pulse beats a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n) done_q <= '0;
        else        done_q <= {seq_rx_done, seq_tx_done} | (done_q & ~clr);
    end

    // Width-dependent thresholds for the level flags.
    always_comb begin
        need     = wide ? CNT_W'(LANES) : CNT_W'(1);
        tx_free  = CNT_W'(DEPTH) - tx_cnt;
        rx_short = rx_cnt < need;
        tx_tight = tx_free < need;
    end

    // Status word assembly.
    always_comb begin
        status            = '0;
        status[ST_TXDONE] = done_q[0];
        status[ST_RXDONE] = done_q[1];
        status[ST_RXAVL]  = !rx_short;
        status[ST_TXAVL]  = !tx_tight;
        status[ST_RXEMP]  = rx_short;
        status[ST_TXFUL]  = tx_tight;
        status[ST_READY]  = seq_idle;
        status[ST_WIDE]   = wide;
    end

    // Interrupt: any enabled event.
    assign irq = |(status[IEN_W-1:0] & ien);

    a_r10_tx_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (status[ST_TXDONE] && !clr[0]) |=> status[ST_TXDONE]);
    a_r10_rx_done_sets: assert property (@(posedge clk) disable iff (!rst_n)
        seq_rx_done |=> status[ST_RXDONE]);
    a_r11_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (ien == '0) |-> !irq);
endmodule

// File: rtl/qspi_fifo_port.sv
`timescale 1ns/1ps
// QSPI FIFO data port (top). Decodes the register bus. It feeds the
// transmit FIFO from the byte or word window, drains the receive FIFO
// through the byte or word window, and offers a byte-stream handshake to
// the serial sequencer.
// Assumes: at most one of bus_wr and bus_rd per cycle; tx_take only while
// tx_valid; rx_valid honoured only while rx_room. LANES = 4, so the data
// word is 32 bits and holds control bit 16.
module qspi_fifo_port
    import qfp_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DEPTH  = 16,
    parameter int LANES  = 4,
    localparam int DATA_W = LANES * 8,
    localparam int CNT_W  = $clog2(DEPTH + 1),
    localparam int LN_W   = $clog2(LANES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [7:0]        tx_byte,
    output logic              tx_valid,
    input  logic              tx_take,
    input  logic [7:0]        rx_byte,
    input  logic              rx_valid,
    output logic              rx_room,
    input  logic              seq_tx_done,
    input  logic              seq_rx_done,
    input  logic              seq_idle,
    output logic              irq
);
    acc_e              acc;
    logic              wide_q;
    logic [IEN_W-1:0]  ien_q;
    logic [DATA_W-1:0] rdata_q, rd_next, status, tx_head, rx_head;
    logic [CNT_W-1:0]  tx_cnt, rx_cnt, tx_free;
    logic [LN_W-1:0]   tx_push_n, tx_pop_n, rx_push_n, rx_pop_n;
    logic [1:0]        stat_clr;

    // Address decode into an access kind.
    always_comb begin
        if      (bus_addr == ADDR_W'(OFS_CTRL)) acc = ACC_CTRL;
        else if (bus_addr == ADDR_W'(OFS_IEN))  acc = ACC_IEN;
        else if (bus_addr == ADDR_W'(OFS_STAT)) acc = ACC_STAT;
        else if (bus_addr == ADDR_W'(OFS_RXB))  acc = ACC_RXB;
        else if (bus_addr == ADDR_W'(OFS_TXB))  acc = ACC_TXB;
        else if (bus_addr == ADDR_W'(OFS_RXW))  acc = ACC_RXW;
        else if (bus_addr == ADDR_W'(OFS_TXW))  acc = ACC_TXW;
        else                                    acc = ACC_NONE;
    end

    assign tx_free = CNT_W'(DEPTH) - tx_cnt;

    // Transmit push: whole access accepted or dropped.
    always_comb begin
        tx_push_n = '0;
        if (bus_wr && acc == ACC_TXB && tx_cnt < CNT_W'(DEPTH))
            tx_push_n = LN_W'(1);
        else if (bus_wr && acc == ACC_TXW && wide_q && tx_free >= CNT_W'(LANES))
            tx_push_n = LN_W'(LANES);
    end

    // Receive pop: only when the full width is buffered.
    always_comb begin
        rx_pop_n = '0;
        if (bus_rd && acc == ACC_RXB && rx_cnt != '0)
            rx_pop_n = LN_W'(1);
        else if (bus_rd && acc == ACC_RXW && wide_q && rx_cnt >= CNT_W'(LANES))
            rx_pop_n = LN_W'(LANES);
    end

    // Sequencer-side handshakes.
    assign tx_valid  = tx_cnt != '0;
    assign tx_byte   = tx_head[7:0];
    assign tx_pop_n  = (tx_valid && tx_take) ? LN_W'(1) : '0;
    assign rx_room   = rx_cnt < CNT_W'(DEPTH);
    assign rx_push_n = (rx_valid && rx_room) ? LN_W'(1) : '0;

    qfp_fifo #(.DEPTH(DEPTH), .LANES(LANES)) u_txq (
        .clk(clk), .rst_n(rst_n),
        .push_n(tx_push_n), .push_data(bus_wdata),
        .pop_n(tx_pop_n), .head(tx_head), .count(tx_cnt)
    );

    qfp_fifo #(.DEPTH(DEPTH), .LANES(LANES)) u_rxq (
        .clk(clk), .rst_n(rst_n),
        .push_n(rx_push_n), .push_data({{(DATA_W-8){1'b0}}, rx_byte}),
        .pop_n(rx_pop_n), .head(rx_head), .count(rx_cnt)
    );

    assign stat_clr = (bus_wr && acc == ACC_STAT) ? bus_wdata[1:0] : 2'b00;

    qfp_status #(.DEPTH(DEPTH), .LANES(LANES), .DATA_W(DATA_W)) u_stat (
        .clk(clk), .rst_n(rst_n),
        .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .wide(wide_q),
        .seq_tx_done(seq_tx_done), .seq_rx_done(seq_rx_done),
        .seq_idle(seq_idle), .clr(stat_clr), .ien(ien_q),
        .status(status), .irq(irq)
    );

    // Configuration registers: wide flag and interrupt enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wide_q <= 1'b0;
            ien_q  <= '0;
        end else if (bus_wr) begin
            if (acc == ACC_CTRL) wide_q <= bus_wdata[CTRL_WIDE_BIT];
            if (acc == ACC_IEN)  ien_q  <= bus_wdata[IEN_W-1:0];
        end
    end

    // Read mux: FIFO windows return zero when the access would underflow.
    always_comb begin
        rd_next = '0;
        case (acc)
            ACC_CTRL: rd_next[CTRL_WIDE_BIT] = wide_q;
            ACC_IEN:  rd_next[IEN_W-1:0]     = ien_q;
            ACC_STAT: rd_next = status;
            ACC_RXB:  if (rx_pop_n != '0) rd_next[7:0] = rx_head[7:0];
            ACC_RXW:  if (rx_pop_n != '0) rd_next = rx_head;
            default:  rd_next = '0;
        endcase
    end

    // Registered read data, updated only on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)      rdata_q <= '0;
        else if (bus_rd) rdata_q <= rd_next;
    end

    assign bus_rdata = rdata_q;

    a_r8_empty_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && acc == ACC_RXB && rx_cnt == '0) |=> (bus_rdata == '0));
    a_r4_narrow_word_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && acc == ACC_TXW && !wide_q && !tx_take) |=> $stable(tx_cnt));
    a_r7_full_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && acc == ACC_TXB && tx_cnt == CNT_W'(DEPTH) && !tx_take)
        |=> (tx_cnt == CNT_W'(DEPTH)));
    a_r12_rx_room_at_full: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_cnt == CNT_W'(DEPTH)) |-> !rx_room);
endmodule

// File: tb/tb_qspi_fifo_port.sv
`timescale 1ns/1ps
module tb_qspi_fifo_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  tx_byte;
    logic        tx_valid, rx_room, irq;
    logic        tx_take = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        rx_valid = 1'b0;
    logic        seq_tx_done = 1'b0, seq_rx_done = 1'b0, seq_idle = 1'b0;

    int errors = 0;
    int checks = 0;
    logic [7:0] exp_tx[$];
    logic [7:0] rxq[$];
    bit m_wide = 0, m_txd = 0, m_rxd = 0;

    always #2.5 clk = ~clk;

    qspi_fifo_port dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tx_byte(tx_byte), .tx_valid(tx_valid), .tx_take(tx_take),
        .rx_byte(rx_byte), .rx_valid(rx_valid), .rx_room(rx_room),
        .seq_tx_done(seq_tx_done), .seq_rx_done(seq_rx_done),
        .seq_idle(seq_idle), .irq(irq)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_stat();
        int need = m_wide ? 4 : 1;
        logic [31:0] s = '0;
        s[0] = m_txd; s[1] = m_rxd;
        s[4] = rxq.size() < need;  s[2] = !s[4];
        s[5] = (16 - exp_tx.size()) < need; s[3] = !s[5];
        s[7] = seq_idle; s[8] = m_wide;
        return s;
    endfunction

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(posedge clk); #1;
        bus_addr = a; bus_rd = 1'b1;
        @(posedge clk); #1;
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    // Driver: transmit byte write; the scoreboard gets the byte if it fits (R2, R7).
    task automatic tx_put_byte(input logic [7:0] b);
        if (exp_tx.size() < 16) exp_tx.push_back(b);
        bus_write(8'h44, {24'hC3A5F0, b});
    endtask

    // Driver: transmit word write, bits 7:0 first (R5, R7, R4).
    task automatic tx_put_word(input logic [31:0] w);
        if (m_wide && (16 - exp_tx.size()) >= 4)
            for (int i = 0; i < 4; i++) exp_tx.push_back(w[8*i +: 8]);
        bus_write(8'h4C, w);
    endtask

    task automatic drain_tx(input int n);
        @(posedge clk); #1; tx_take = 1'b1;
        repeat (n) @(posedge clk);
        #1; tx_take = 1'b0;
    endtask

    // Sequencer feeds one receive byte (R12).
    task automatic rx_feed(input logic [7:0] b);
        if (rxq.size() < 16) rxq.push_back(b);
        @(posedge clk); #1; rx_byte = b; rx_valid = 1'b1;
        @(posedge clk); #1; rx_valid = 1'b0;
    endtask

    task automatic rd_rx_byte(input string req);
        logic [31:0] d, e;
        e = '0;
        if (rxq.size() > 0) e[7:0] = rxq.pop_front();
        bus_read(8'h40, d);
        chk(d === e, req, d, e);
    endtask

    task automatic rd_rx_word(input string req);
        logic [31:0] d, e;
        e = '0;
        if (m_wide && rxq.size() >= 4)
            for (int i = 0; i < 4; i++) e[8*i +: 8] = rxq.pop_front();
        bus_read(8'h48, d);
        chk(d === e, req, d, e);
    endtask

    task automatic chk_status(input string req);
        logic [31:0] d, e;
        e = exp_stat();
        bus_read(8'h10, d);
        chk(d === e, req, d, e);
    endtask

    // Monitor: every consumed transmit byte must match the scoreboard head (R2, R5, R12).
    always @(negedge clk) begin
        if (rst_n && tx_valid && tx_take) begin
            checks++;
            if (exp_tx.size() == 0) begin
                errors++;
                $display("FAIL R12: actual=%h expected=<none queued>", tx_byte);
            end else begin
                logic [7:0] e;
                e = exp_tx.pop_front();
                if (tx_byte !== e) begin
                    errors++;
                    $display("FAIL R2/R5: actual=%h expected=%h", tx_byte, e);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(posedge clk);
        #1; rst_n = 1'b1;

        // R1 reset state
        bus_read(8'h10, d);   chk(d === 32'h18, "R1 status", d, 32'h18);
        bus_read(8'h0C, d);   chk(d === 32'h0, "R1 ien", d, 32'h0);
        bus_read(8'h00, d);   chk(d === 32'h0, "R1 ctrl", d, 32'h0);
        chk(irq === 1'b0 && tx_valid === 1'b0 && rx_room === 1'b1, "R1 outputs",
            {29'b0, irq, tx_valid, rx_room}, 32'h1);

        // R2 byte transmit, upper bits ignored
        tx_put_byte(8'hA1); tx_put_byte(8'hB2); tx_put_byte(8'h07);
        drain_tx(3);
        chk(tx_valid === 1'b0 && exp_tx.size() == 0, "R2 drained", {31'b0, tx_valid}, 0);

        // R3 and R12 byte receive in order
        rx_feed(8'h10); rx_feed(8'h9E); rx_feed(8'hFF);
        rd_rx_byte("R3 first"); rd_rx_byte("R3 second"); rd_rx_byte("R3 third");

        // R8 empty read returns zero, then next byte is still intact
        rd_rx_byte("R8 empty byte read");
        rx_feed(8'h5A);
        rd_rx_byte("R8 after empty read");

        // R4 word windows inactive while the flag is clear
        tx_put_word(32'hDEADBEEF);
        chk(tx_valid === 1'b0, "R4 narrow word write", {31'b0, tx_valid}, 0);
        rx_feed(8'h01); rx_feed(8'h02); rx_feed(8'h03); rx_feed(8'h04);
        rd_rx_word("R4 narrow word read");
        chk_status("R4 status bit8 clear");

        // R4 set flag, read back and mirror
        bus_write(8'h00, 32'h0001_0000); m_wide = 1;
        bus_read(8'h00, d); chk(d === 32'h0001_0000, "R4 ctrl readback", d, 32'h0001_0000);
        chk_status("R4 status bit8 set");

        // R6 word receive of the four bytes held back above
        rd_rx_word("R6 word read");

        // R5 word transmit ordering
        tx_put_word(32'h4433_2211);
        tx_put_word(32'h8877_6655);
        drain_tx(8);
        chk(exp_tx.size() == 0, "R5 all consumed", exp_tx.size(), 0);

        // R9 and R8 receive threshold in wide mode
        rx_feed(8'hA0); rx_feed(8'hA1); rx_feed(8'hA2);
        chk_status("R9 three bytes wide: rx empty");
        rd_rx_word("R8 short word read");
        rx_feed(8'hA3);
        chk_status("R9 four bytes wide: rx available");
        rd_rx_word("R6 word read after threshold");

        // R9 and R7 transmit threshold in wide mode
        tx_put_word(32'h0302_0100); tx_put_word(32'h0706_0504); tx_put_word(32'h0B0A_0908);
        chk_status("R9 twelve queued wide: space");
        tx_put_byte(8'h0C);
        chk_status("R9 thirteen queued wide: full");
        tx_put_word(32'hBADBADBA);
        chk_status("R7 wide write dropped");
        drain_tx(13);
        chk(tx_valid === 1'b0, "R7 only thirteen queued", {31'b0, tx_valid}, 0);

        // R7 byte mode full at sixteen
        bus_write(8'h00, 32'h0); m_wide = 0;
        for (int i = 0; i < 16; i++) tx_put_byte(8'h40 + 8'(i));
        chk_status("R9 sixteen queued: full");
        tx_put_byte(8'hEE);
        drain_tx(16);
        chk(tx_valid === 1'b0, "R7 extra byte dropped", {31'b0, tx_valid}, 0);

        // R12 receive room at sixteen, overfill ignored
        for (int i = 0; i < 16; i++) rx_feed(8'h80 + 8'(i));
        chk(rx_room === 1'b0, "R12 rx room low when full", {31'b0, rx_room}, 0);
        rx_feed(8'h77);
        for (int i = 0; i < 16; i++) rd_rx_byte("R12 receive order");
        rd_rx_byte("R12 overfill byte absent");

        // R10 sticky done flags, write-one clear, ready mirror
        @(posedge clk); #1; seq_tx_done = 1'b1; seq_idle = 1'b1;
        @(posedge clk); #1; seq_tx_done = 1'b0; m_txd = 1;
        repeat (3) @(posedge clk);
        chk_status("R10 tx done held, ready set");
        @(posedge clk); #1; seq_rx_done = 1'b1;
        @(posedge clk); #1; seq_rx_done = 1'b0; m_rxd = 1;
        bus_write(8'h10, 32'h1); m_txd = 0;
        chk_status("R10 tx done cleared, rx done kept");

        // R11 interrupt masking
        bus_write(8'h0C, 32'h02);
        bus_read(8'h0C, d); chk(d === 32'h02, "R11 ien readback", d, 32'h02);
        chk(irq === 1'b1, "R11 irq rx done enabled", {31'b0, irq}, 1);
        bus_write(8'h10, 32'h2); m_rxd = 0;
        chk(irq === 1'b0, "R11 irq after clear", {31'b0, irq}, 0);
        bus_write(8'h0C, 32'h08);
        chk(irq === 1'b1, "R11 irq tx space", {31'b0, irq}, 1);
        bus_write(8'h0C, 32'h20);
        chk(irq === 1'b0, "R11 irq tx full masked in", {31'b0, irq}, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule